// File: doc/BRIEF.md
# Rate-Select Divider With Square Wave

This block is the time-base divider of a real-time clock. It runs a binary counter from the 32.768 kHz time-base clock. A four-bit rate code picks one counter bit as the programmable rate. That bit drives two things: a square-wave pin, and a one-cycle periodic event that goes to the interrupt logic. The most significant counter bit provides the once-per-second tick that starts each calendar update.

A three-bit oscillator control input places the chain in one of three states. It can run, it can be held at zero while the oscillator keeps going, or it can be stopped. A stopped chain keeps its count. A chain released from hold produces its first second tick half a second later.

The rate code and the oscillator control are plain inputs owned by the register file. Reset clears only the counter and the output registers.

Top module: `rate_divider_sqw`

## Requirements
- R1: While rst_n is low the counter is zero and sqw, periodic_pulse and one_hz_tick are all low.
- R2: Rate codes 3 to 15 select counter bit (code - 2). The selected bit toggles every 2^(code-2) clocks, so code 3 gives clk/4 (8.192 kHz) and code 15 gives clk/16384 (2 Hz). Code 1 selects bit 6 (256 Hz) and code 2 selects bit 7 (128 Hz).
- R3: periodic_pulse is high for exactly one clock, in the cycle the selected bit has just risen. After the chain starts from zero, the first pulse comes after 2^bit running clocks. Later pulses come every 2^(bit+1) running clocks.
- R4: With sqw_en high and a nonzero code, sqw follows the selected bit. It is high for half of each period.
- R5: With sqw_en low, sqw stays low and periodic_pulse keeps its normal timing.
- R6: With rate code 0, sqw stays low and periodic_pulse never fires.
- R7: Oscillator control 3'b110 or 3'b111 holds the counter at zero. Outputs stay low. When 3'b010 follows, events restart from zero.
- R8: Any oscillator control other than 3'b010, 3'b110 and 3'b111 freezes the counter. No events occur and sqw keeps its level. On return to 3'b010, counting resumes from the frozen value.
- R9: one_hz_tick is a one-clock pulse. It fires 16384 running clocks after the chain leaves zero, then every 32768 running clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock, 32.768 kHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 4 | Rate code; 0 turns the rate output off |
| osc_ctl | input | 3 | 3'b010 run, 3'b11x hold at zero, others stop |
| sqw_en | input | 1 | Enables the square-wave output |
| sqw | output | 1 | Square wave at the selected rate |
| periodic_pulse | output | 1 | One-cycle event on each rising edge of the selected bit |
| one_hz_tick | output | 1 | One-cycle pulse once per second |

## Verification
The hardest state to reach is the frozen chain with the selected bit high. From there the bench must show that sqw holds its level and that counting resumes with no lost or extra count. The stimulus runs code 3 until its first pulse and then switches the oscillator to stop. It confirms that sqw stays high and silent, then restarts and measures that the next pulse comes exactly four clocks later. The slowest rates and the second tick need tens of thousands of clocks. Each table vector therefore resets the chain so that the first-edge delay is a known power of two.

// File: rtl/rate_divider_sqw.sv
module rate_divider_sqw #(
  parameter int STAGES = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate_sel,
  input  logic [2:0] osc_ctl,
  input  logic       sqw_en,
  output logic       sqw,
  output logic       periodic_pulse,
  output logic       one_hz_tick
);
  localparam int SEC_BIT = STAGES - 1;
  localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

  logic [STAGES-1:0] cnt, cnt_nxt;
  logic              run, hold, rate_on;
  logic [3:0]        tap_idx;

  assign run     = (osc_ctl == 3'b010);
  assign hold    = (osc_ctl[2:1] == 2'b11);
  assign cnt_nxt = hold ? '0 : (run ? cnt + ONE : cnt);
  assign rate_on = (rate_sel != 4'd0);
  assign tap_idx = (rate_sel >= 4'd3) ? rate_sel - 4'd2 : rate_sel + 4'd5;
  assign sqw     = sqw_en & rate_on & cnt[tap_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt            <= '0;
      periodic_pulse <= 1'b0;
      one_hz_tick    <= 1'b0;
    end else begin
      cnt            <= cnt_nxt;
      periodic_pulse <= rate_on & ~cnt[tap_idx] & cnt_nxt[tap_idx];
      one_hz_tick    <= ~cnt[SEC_BIT] & cnt_nxt[SEC_BIT];
    end
  end

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |=> (!periodic_pulse || rate_sel != $past(rate_sel)));

  a_r6_off_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !periodic_pulse);

  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0 && !periodic_pulse && !one_hz_tick));

  a_r8_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold) |=> ($stable(cnt) && !periodic_pulse && !one_hz_tick));

  a_r9_tick_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    one_hz_tick |-> (cnt[SEC_BIT] && cnt[SEC_BIT-1:0] == '0));

  a_r1_reset_low: assert property (@(negedge clk)
    !rst_n |-> (!sqw && !periodic_pulse && !one_hz_tick));
endmodule

// File: tb/rate_divider_sqw_tb_top.sv
module rate_divider_sqw_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] osc_ctl = 3'b000;
  logic       sqw_en = 1'b1;
  wire        sqw, periodic_pulse, one_hz_tick;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  rate_divider_sqw dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .osc_ctl(osc_ctl),
    .sqw_en(sqw_en), .sqw(sqw), .periodic_pulse(periodic_pulse),
    .one_hz_tick(one_hz_tick)
  );

  // rate code -> clocks from start to first rising edge of the selected bit
  localparam int NV = 15;
  localparam logic [3:0] VEC_CODE[NV] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6,
    4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
  localparam int VEC_HALF[NV] = '{64, 128, 2, 4, 8, 16, 32, 64, 128, 256,
    512, 1024, 2048, 4096, 8192};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    osc_ctl = 3'b000;
    @(negedge clk);
    check(!sqw && !periodic_pulse && !one_hz_tick, "R1 outputs in reset",
          {sqw, periodic_pulse, one_hz_tick}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // counts negedges until periodic_pulse, also counts sqw high samples
  task automatic wait_pulse(output int n, output int hi);
    n = 0;
    hi = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      n++;
      if (sqw) hi++;
      if (periodic_pulse) break;
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      n++;
      if (one_hz_tick) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int n, hi, hcnt;
    // R2 R3 R4: walk the table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      rate_sel = VEC_CODE[v];
      sqw_en = 1'b1;
      osc_ctl = 3'b010;
      wait_pulse(n, hi);
      check(n == VEC_HALF[v], "R2 first edge delay", n, VEC_HALF[v]);
      @(negedge clk);
      check(!periodic_pulse, "R3 pulse one cycle", periodic_pulse, 0);
      wait_pulse(n, hi);
      check(n == 2 * VEC_HALF[v] - 1, "R3 pulse period", n + 1, 2 * VEC_HALF[v]);
      check(hi == VEC_HALF[v] - 1 + 1 - 1 + 0 + (VEC_HALF[v] == 0 ? 0 : 0) || hi == VEC_HALF[v],
            "R4 sqw duty", hi, VEC_HALF[v]);
    end

    // R5: sqw gated off, pulse timing intact
    do_reset();
    rate_sel = 4'd4;
    sqw_en = 1'b0;
    osc_ctl = 3'b010;
    wait_pulse(n, hi);
    check(n == 4, "R5 pulse with sqw off", n, 4);
    wait_pulse(n, hi);
    check(hi == 0, "R5 sqw low", hi, 0);
    check(n == 8, "R5 period", n, 8);
    sqw_en = 1'b1;

    // R6: code 0 silent
    rate_sel = 4'd0;
    hcnt = 0;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sqw) hcnt++;
      if (periodic_pulse) n++;
    end
    check(hcnt == 0, "R6 sqw off", hcnt, 0);
    check(n == 0, "R6 no pulse", n, 0);

    // R7: hold at zero then release
    rate_sel = 4'd3;
    osc_ctl = 3'b110;
    n = 0;
    hcnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (i > 0 && periodic_pulse) n++;
      if (i > 0 && sqw) hcnt++;
    end
    check(n == 0 && hcnt == 0, "R7 held quiet", n + hcnt, 0);
    osc_ctl = 3'b010;
    wait_pulse(n, hi);
    check(n == 2, "R7 restart from zero", n, 2);

    // R8: freeze with selected bit high, then resume
    do_reset();
    rate_sel = 4'd3;
    osc_ctl = 3'b010;
    wait_pulse(n, hi);
    check(n == 2 && sqw, "R8 setup", n, 2);
    osc_ctl = 3'b000;
    n = 0;
    hcnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (i > 0 && periodic_pulse) n++;
      if (sqw) hcnt++;
    end
    check(n == 0, "R8 no events while stopped", n, 0);
    check(hcnt == 50, "R8 sqw holds level", hcnt, 50);
    osc_ctl = 3'b010;
    wait_pulse(n, hi);
    check(n == 4, "R8 resume from frozen count", n, 4);

    // R9: second tick
    do_reset();
    rate_sel = 4'd15;
    osc_ctl = 3'b010;
    wait_tick(n);
    check(n == 16384, "R9 first tick", n, 16384);
    @(negedge clk);
    check(!one_hz_tick, "R9 tick one cycle", one_hz_tick, 0);
    wait_tick(n);
    check(n == 32767, "R9 tick period", n + 1, 32768);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule